// File: doc/BRIEF.md
# PCI Target Command Decoder

This block sits on the shared PCI bus beside a 32-bit target. It finds the first clock of each transaction, that is, the first clock with FRAME# low after the bus was idle. On that clock it reads the bus command from C/BE# and the address from AD. From these it decides whether the target takes the cycle. It takes Type 0 configuration reads and writes when IDSEL is high. It takes memory reads and writes that fall inside a 1 KB aligned window set by a base address input. It takes interrupt acknowledge only while a separate enable input allows it.

Every other command gets no response, so the initiator finishes with a master abort. This covers special cycles, the reserved codes, dual-address cycles and all commands this target does not implement. Only the first clock of a transaction is decoded. A command code or address that shows up later in the same transaction, such as the second address dword of a dual-address cycle, is ignored.

When the target takes a cycle, the block drives DEVSEL# low with medium decode timing and pulses a claim strobe. It also holds a one-hot class flag for the data-phase engine that follows it. DEVSEL# and the flag stay valid until the bus is idle again.

Top module: `pci_tgt_claim`

## Requirements
- R1: While reset is low, and after reset until the first claim, `tgt_devsel_n` is 1 and `tgt_claim` and all class flags are 0.
- R2: A configuration read (command 1010) or write (command 1011) is claimed when `bus_idsel` is 1 and AD[1:0] is 00. The claim raises `cls_cfg_rd` or `cls_cfg_wr` respectively.
- R3: A configuration command is not claimed when AD[1:0] is 01, 10 or 11, or when `bus_idsel` is 0.
- R4: A memory read (0110) or write (0111) is claimed when `cfg_mem_en` is 1 and AD[31:10] equals `cfg_bar`[31:10]. AD[9:0] and `cfg_bar`[9:0] do not affect the result. The claim raises `cls_mem_rd` or `cls_mem_wr`.
- R5: A memory command is not claimed while `cfg_mem_en` is 0, or when the upper address bits differ from the window.
- R6: Interrupt acknowledge (0000) is claimed, with `cls_iack`, only while `cfg_iack_en` is 1. The address does not matter.
- R7: Special cycle (0001), the reserved codes 0100, 0101, 1000 and 1001, dual-address cycle (1101), and every other code not named in R2, R4 or R6 are never claimed. This holds whatever the enables, IDSEL or address are.
- R8: Call the rising edge that samples the first FRAME#-low clock the address edge. DEVSEL# stays high after the address edge. DEVSEL# goes low, and the claim strobe is high for exactly one cycle, after the next rising edge. The class flag becomes valid at that same edge.
- R9: While FRAME# or IRDY# stays low, DEVSEL# and the class flag hold. After the first rising edge that samples both high, DEVSEL# is 1 and all flags are 0.
- R10: Clocks with FRAME# low that follow the address edge in the same transaction are not decoded. This includes the second dword of a dual-address cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_frame_n | input | 1 | FRAME#, active low |
| bus_irdy_n | input | 1 | IRDY#, active low |
| bus_ad | input | ADDR_W | Address/data bus |
| bus_cbe_n | input | 4 | Command / byte enables |
| bus_idsel | input | 1 | Configuration select for this device |
| cfg_mem_en | input | 1 | Memory space enable from the command register |
| cfg_iack_en | input | 1 | Allows interrupt acknowledge to be claimed |
| cfg_bar | input | ADDR_W | Memory window base; low WIN_BITS bits ignored |
| tgt_devsel_n | output | 1 | DEVSEL#, active low |
| tgt_claim | output | 1 | One-cycle strobe when a transaction is claimed |
| cls_cfg_rd | output | 1 | Claimed cycle is a configuration read |
| cls_cfg_wr | output | 1 | Claimed cycle is a configuration write |
| cls_mem_rd | output | 1 | Claimed cycle is a memory read |
| cls_mem_wr | output | 1 | Claimed cycle is a memory write |
| cls_iack | output | 1 | Claimed cycle is an interrupt acknowledge |

## Verification
The timing counts from the rising edge that samples the address phase. One edge later the decision is held internally and DEVSEL# must still be high. After the second edge DEVSEL#, the claim strobe and the class flag are all due. Release comes one edge after the bus is sampled idle. The bench drives the bus on falling edges and samples on the falling edge after each of these rising edges, so every result is compared in the one cycle it is due. Expected flags come from a bench function over the command, address, IDSEL and enables. The enables and the window base change only between transactions.

// File: rtl/pci_tdec_pkg.sv
// Package: command codes and the claim class shared by the decoder pieces.
// Assumes the bus command is read as the raw C/BE# value of the address phase.
package pci_tdec_pkg;
    localparam logic [3:0] CMD_IACK   = 4'b0000;
    localparam logic [3:0] CMD_SPEC   = 4'b0001;
    localparam logic [3:0] CMD_MEM_RD = 4'b0110;
    localparam logic [3:0] CMD_MEM_WR = 4'b0111;
    localparam logic [3:0] CMD_CFG_RD = 4'b1010;
    localparam logic [3:0] CMD_CFG_WR = 4'b1011;
    localparam logic [3:0] CMD_DAC    = 4'b1101;

    typedef enum logic [2:0] {
        CLS_NONE   = 3'd0,
        CLS_CFG_RD = 3'd1,
        CLS_CFG_WR = 3'd2,
        CLS_MEM_RD = 3'd3,
        CLS_MEM_WR = 3'd4,
        CLS_IACK   = 3'd5
    } claim_cls_e;
endpackage

// File: rtl/pci_bus_track.sv
// Bus phase tracker: marks the first FRAME#-low clock after idle as the
// address phase and reports when the bus is sampled idle.
// Assumes no fast back-to-back transactions (an idle clock separates them).
module pci_bus_track (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_n,
    input  logic irdy_n,
    output logic addr_phase,
    output logic bus_idle
);
    logic busy_q;

    assign bus_idle   = frame_n && irdy_n;
    assign addr_phase = !frame_n && !busy_q;

    // Purpose: remember that a transaction is in progress until idle is seen.
    always_ff @(posedge clk) begin
        if (!rst_n)
            busy_q <= 1'b0;
        else if (bus_idle)
            busy_q <= 1'b0;
        else if (!frame_n)
            busy_q <= 1'b1;
    end
endmodule

// File: rtl/pci_bar_match.sv
// Window compare: the address hits when its bits above WIN_BITS equal the
// base. Base bits below WIN_BITS are treated as zero.
// Assumes WIN_BITS < ADDR_W; a window covering the whole space always hits.
module pci_bar_match #(
    parameter int ADDR_W   = 32,
    parameter int WIN_BITS = 10
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] base,
    output logic              hit
);
    generate
        if (WIN_BITS >= ADDR_W) begin : g_all
            logic [ADDR_W-1:0] diff_all;
            assign diff_all = addr ^ base;
            assign hit = 1'b1 | (&diff_all);
        end else begin : g_cmp
            localparam logic [ADDR_W-1:0] UP_MASK = {{(ADDR_W-WIN_BITS){1'b1}}, {WIN_BITS{1'b0}}};
            assign hit = ((addr ^ base) & UP_MASK) == '0;
        end
    endgenerate
endmodule

// File: rtl/pci_cmd_classify.sv
// Command classifier: maps one address phase to the class the target claims,
// or CLS_NONE for anything refused (special, reserved, DAC, unimplemented).
// Assumes inputs are valid only while addr_phase is asserted upstream.
module pci_cmd_classify
    import pci_tdec_pkg::*;
(
    input  logic [3:0]  cmd,
    input  logic [1:0]  ad_lo,
    input  logic        idsel,
    input  logic        mem_en,
    input  logic        iack_en,
    input  logic        win_hit,
    output claim_cls_e  cls
);
    logic cfg_ok;
    logic mem_ok;

    assign cfg_ok = idsel && (ad_lo == 2'b00);
    assign mem_ok = mem_en && win_hit;

    // Purpose: one-level decode of the command code with its qualifier.
    always_comb begin
        cls = CLS_NONE;
        case (cmd)
            CMD_CFG_RD: if (cfg_ok)  cls = CLS_CFG_RD;
            CMD_CFG_WR: if (cfg_ok)  cls = CLS_CFG_WR;
            CMD_MEM_RD: if (mem_ok)  cls = CLS_MEM_RD;
            CMD_MEM_WR: if (mem_ok)  cls = CLS_MEM_WR;
            CMD_IACK:   if (iack_en) cls = CLS_IACK;
            default:                 cls = CLS_NONE;
        endcase
    end
endmodule

// File: rtl/pci_tgt_claim.sv
// Target claim logic: decodes each address phase, then drives DEVSEL# with
// medium timing (one register stage of decision, one of drive), pulses a claim
// strobe and holds a one-hot class flag until the bus returns to idle.
// Assumes a 32-bit-only target; the second dword of a DAC is never decoded.
module pci_tgt_claim
    import pci_tdec_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int WIN_BITS = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_frame_n,
    input  logic              bus_irdy_n,
    input  logic [ADDR_W-1:0] bus_ad,
    input  logic [3:0]        bus_cbe_n,
    input  logic              bus_idsel,
    input  logic              cfg_mem_en,
    input  logic              cfg_iack_en,
    input  logic [ADDR_W-1:0] cfg_bar,
    output logic              tgt_devsel_n,
    output logic              tgt_claim,
    output logic              cls_cfg_rd,
    output logic              cls_cfg_wr,
    output logic              cls_mem_rd,
    output logic              cls_mem_wr,
    output logic              cls_iack
);
    logic       addr_phase;
    logic       bus_idle;
    logic       win_hit;
    claim_cls_e dec_cls;
    logic       pend_q;
    claim_cls_e pend_cls_q;
    claim_cls_e cur_cls_q;
    logic       devsel_q;
    logic       claim_q;

    pci_bus_track u_track (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_n    (bus_frame_n),
        .irdy_n     (bus_irdy_n),
        .addr_phase (addr_phase),
        .bus_idle   (bus_idle)
    );

    pci_bar_match #(.ADDR_W(ADDR_W), .WIN_BITS(WIN_BITS)) u_bar (
        .addr (bus_ad),
        .base (cfg_bar),
        .hit  (win_hit)
    );

    pci_cmd_classify u_cls (
        .cmd     (bus_cbe_n),
        .ad_lo   (bus_ad[1:0]),
        .idsel   (bus_idsel),
        .mem_en  (cfg_mem_en),
        .iack_en (cfg_iack_en),
        .win_hit (win_hit),
        .cls     (dec_cls)
    );

    // Purpose: decision stage, captures the class of a claimable address phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q     <= 1'b0;
            pend_cls_q <= CLS_NONE;
        end else begin
            pend_q     <= addr_phase && (dec_cls != CLS_NONE);
            pend_cls_q <= addr_phase ? dec_cls : CLS_NONE;
        end
    end

    // Purpose: drive stage, asserts DEVSEL# and strobe, releases on idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            devsel_q  <= 1'b0;
            claim_q   <= 1'b0;
            cur_cls_q <= CLS_NONE;
        end else if (pend_q) begin
            devsel_q  <= 1'b1;
            claim_q   <= 1'b1;
            cur_cls_q <= pend_cls_q;
        end else begin
            claim_q <= 1'b0;
            if (bus_idle) begin
                devsel_q  <= 1'b0;
                cur_cls_q <= CLS_NONE;
            end
        end
    end

    assign tgt_devsel_n = !devsel_q;
    assign tgt_claim    = claim_q;
    assign cls_cfg_rd   = (cur_cls_q == CLS_CFG_RD);
    assign cls_cfg_wr   = (cur_cls_q == CLS_CFG_WR);
    assign cls_mem_rd   = (cur_cls_q == CLS_MEM_RD);
    assign cls_mem_wr   = (cur_cls_q == CLS_MEM_WR);
    assign cls_iack     = (cur_cls_q == CLS_IACK);
endmodule

// File: rtl/pci_tdec_chk.sv
// Checker for pci_tgt_claim: port-level timing and refusal properties.
// Assumes enables are held stable across a transaction's first two edges.
module pci_tdec_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_frame_n,
    input logic              bus_irdy_n,
    input logic [ADDR_W-1:0] bus_ad,
    input logic [3:0]        bus_cbe_n,
    input logic              bus_idsel,
    input logic              cfg_mem_en,
    input logic              cfg_iack_en,
    input logic              tgt_devsel_n,
    input logic              tgt_claim,
    input logic              cls_cfg_rd,
    input logic              cls_cfg_wr,
    input logic              cls_mem_rd,
    input logic              cls_mem_wr,
    input logic              cls_iack
);
    logic [ADDR_W-1:0] ad_seen;
    assign ad_seen = bus_ad;

    assert_flags_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cls_cfg_rd, cls_cfg_wr, cls_mem_rd, cls_mem_wr, cls_iack}));

    assert_cfg_type0_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt_claim && (cls_cfg_rd || cls_cfg_wr)) |->
        ($past(ad_seen[1:0], 2) == 2'b00 && $past(bus_idsel, 2)));

    assert_mem_enable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt_claim && (cls_mem_rd || cls_mem_wr)) |-> $past(cfg_mem_en, 2));

    assert_iack_enable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt_claim && cls_iack) |-> $past(cfg_iack_en, 2));

    assert_refused_codes_R7: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_claim |-> !($past(bus_cbe_n, 2) inside {4'b0001, 4'b0100, 4'b0101,
                                                    4'b1000, 4'b1001, 4'b1101}));

    assert_claim_with_devsel_R8: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_claim |-> !tgt_devsel_n);

    assert_claim_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_claim |=> !tgt_claim);

    assert_devsel_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tgt_devsel_n) |-> tgt_claim);

    assert_release_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!tgt_devsel_n && bus_frame_n && bus_irdy_n) |=> tgt_devsel_n);
endmodule

bind pci_tgt_claim pci_tdec_chk #(.ADDR_W(ADDR_W)) u_tdec_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_frame_n  (bus_frame_n),
    .bus_irdy_n   (bus_irdy_n),
    .bus_ad       (bus_ad),
    .bus_cbe_n    (bus_cbe_n),
    .bus_idsel    (bus_idsel),
    .cfg_mem_en   (cfg_mem_en),
    .cfg_iack_en  (cfg_iack_en),
    .tgt_devsel_n (tgt_devsel_n),
    .tgt_claim    (tgt_claim),
    .cls_cfg_rd   (cls_cfg_rd),
    .cls_cfg_wr   (cls_cfg_wr),
    .cls_mem_rd   (cls_mem_rd),
    .cls_mem_wr   (cls_mem_wr),
    .cls_iack     (cls_iack)
);

// File: tb/tb_pci_tgt_claim.sv
`timescale 1ns/1ps
module tb_pci_tgt_claim;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_n = 1'b1;
    logic        irdy_n = 1'b1;
    logic [31:0] ad = '0;
    logic [3:0]  cbe_n = '0;
    logic        idsel = 1'b0;
    logic        mem_en = 1'b0;
    logic        iack_en = 1'b0;
    logic [31:0] bar = 32'h2200_0000;
    logic        devsel_n;
    logic        claim;
    logic        f_cr, f_cw, f_mr, f_mw, f_ia;
    int          n_chk = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    pci_tgt_claim dut (
        .clk (clk), .rst_n (rst_n), .bus_frame_n (frame_n), .bus_irdy_n (irdy_n),
        .bus_ad (ad), .bus_cbe_n (cbe_n), .bus_idsel (idsel),
        .cfg_mem_en (mem_en), .cfg_iack_en (iack_en), .cfg_bar (bar),
        .tgt_devsel_n (devsel_n), .tgt_claim (claim),
        .cls_cfg_rd (f_cr), .cls_cfg_wr (f_cw), .cls_mem_rd (f_mr),
        .cls_mem_wr (f_mw), .cls_iack (f_ia)
    );

    function automatic logic [4:0] flags_now();
        return {f_cr, f_cw, f_mr, f_mw, f_ia};
    endfunction

    // Expected class flags {cfg_rd, cfg_wr, mem_rd, mem_wr, iack} from R2..R7.
    function automatic logic [4:0] exp_flags(input logic [3:0] c, input logic [31:0] a,
                                             input logic sel, input logic me,
                                             input logic ia, input logic [31:0] b);
        logic hit;
        hit = (a[31:10] == b[31:10]);
        case (c)
            4'b1010: return (sel && a[1:0] == 2'b00) ? 5'b10000 : 5'b00000;
            4'b1011: return (sel && a[1:0] == 2'b00) ? 5'b01000 : 5'b00000;
            4'b0110: return (me && hit) ? 5'b00100 : 5'b00000;
            4'b0111: return (me && hit) ? 5'b00010 : 5'b00000;
            4'b0000: return ia ? 5'b00001 : 5'b00000;
            default: return 5'b00000;
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, expv, $time);
        end
    endtask

    // One transaction: address phase, L data clocks (FRAME# low on all but the
    // last), then idle. Second clock carries c2/a2 to probe R10.
    task automatic txn(input logic [3:0] c, input logic [31:0] a, input logic sel,
                       input int L, input logic [3:0] c2, input logic [31:0] a2,
                       input string req);
        logic [4:0] e;
        logic       cl;
        e  = exp_flags(c, a, sel, mem_en, iack_en, bar);
        cl = |e;
        @(negedge clk);
        frame_n = 1'b0; irdy_n = 1'b1; cbe_n = c; ad = a; idsel = sel;
        for (int k = 1; k <= L + 1; k++) begin
            @(negedge clk);
            if (k == 1)
                chk(devsel_n && !claim, "R8", {devsel_n, claim}, 2'b10);
            else if (k == 2) begin
                chk(devsel_n == !cl && claim == cl, "R8", {devsel_n, claim}, {!cl, cl});
                chk(flags_now() == e, req, flags_now(), e);
            end else
                chk(devsel_n == !cl && !claim && flags_now() == e, "R9",
                    {devsel_n, claim, flags_now()}, {!cl, 1'b0, e});
            if (k <= L) begin
                frame_n = (k == L); irdy_n = 1'b0;
                cbe_n = (k == 1) ? c2 : 4'($urandom);
                ad    = (k == 1) ? a2 : $urandom;
                idsel = (k == 1) ? 1'b1 : 1'b0;
            end else begin
                frame_n = 1'b1; irdy_n = 1'b1; idsel = 1'b0;
            end
        end
        @(negedge clk);
        chk(devsel_n && !claim && flags_now() == 5'b0, "R9",
            {devsel_n, claim, flags_now()}, {1'b1, 1'b0, 5'b0});
    endtask

    initial begin
        #(5.0 * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] hit_a;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk(devsel_n && !claim && flags_now() == 5'b0, "R1",
            {devsel_n, claim, flags_now()}, 32'h100);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(devsel_n && !claim && flags_now() == 5'b0, "R1",
            {devsel_n, claim, flags_now()}, 32'h100);

        // Configuration cycles
        txn(4'b1010, 32'h0000_0000, 1'b1, 1, 4'h0, 32'h0, "R2");
        txn(4'b1011, 32'h0000_0010, 1'b1, 2, 4'h0, 32'h0, "R2");
        txn(4'b1010, 32'h0000_0001, 1'b1, 1, 4'h0, 32'h0, "R3");
        txn(4'b1011, 32'h0000_0002, 1'b1, 1, 4'h0, 32'h0, "R3");
        txn(4'b1010, 32'h0000_0003, 1'b1, 1, 4'h0, 32'h0, "R3");
        txn(4'b1011, 32'h0000_0000, 1'b0, 1, 4'h0, 32'h0, "R3");

        // Memory window
        txn(4'b0110, 32'h2200_0110, 1'b0, 1, 4'h0, 32'h0, "R5");
        mem_en = 1'b1;
        txn(4'b0110, 32'h2200_03FF, 1'b0, 3, 4'h0, 32'h0, "R4");
        bar = 32'h2200_02A5;
        txn(4'b0111, 32'h2200_0000, 1'b0, 1, 4'h0, 32'h0, "R4");
        txn(4'b0111, 32'h2200_0400, 1'b0, 1, 4'h0, 32'h0, "R5");
        txn(4'b0110, 32'hA200_0000, 1'b0, 1, 4'h0, 32'h0, "R5");

        // Interrupt acknowledge
        txn(4'b0000, 32'h2200_0110, 1'b0, 1, 4'h0, 32'h0, "R6");
        iack_en = 1'b1;
        txn(4'b0000, 32'h1234_5678, 1'b0, 1, 4'h0, 32'h0, "R6");

        // Refused codes, enables on, address hitting
        foreach (bar[i]) if (i < 1) ;
        txn(4'b0001, 32'h2200_0110, 1'b1, 1, 4'h0, 32'h0, "R7");
        txn(4'b0100, 32'h2200_0110, 1'b1, 1, 4'h0, 32'h0, "R7");
        txn(4'b0101, 32'h2200_0110, 1'b1, 1, 4'h0, 32'h0, "R7");
        txn(4'b1000, 32'h0000_0000, 1'b1, 1, 4'h0, 32'h0, "R7");
        txn(4'b1001, 32'h0000_0000, 1'b1, 1, 4'h0, 32'h0, "R7");
        txn(4'b1101, 32'h2200_0110, 1'b1, 2, 4'b0110, 32'h2200_0110, "R7");

        // Later FRAME#-low clocks are not decoded
        txn(4'b0101, 32'h0, 1'b0, 4, 4'b1010, 32'h0, "R10");
        txn(4'b1101, 32'h2200_0000, 1'b0, 3, 4'b0111, 32'h2200_0004, "R10");

        // Random mix
        for (int t = 0; t < 400; t++) begin
            logic [3:0]  c;
            logic [31:0] a;
            int          gap;
            if ($urandom_range(0, 15) == 0) mem_en  = 1'($urandom);
            if ($urandom_range(0, 15) == 0) iack_en = 1'($urandom);
            if ($urandom_range(0, 31) == 0) bar     = $urandom;
            c = 4'($urandom);
            hit_a = {bar[31:10], 10'($urandom)};
            a = $urandom_range(0, 1) ? hit_a : $urandom;
            if ($urandom_range(0, 1) && (c == 4'b1010 || c == 4'b1011)) a[1:0] = 2'b00;
            txn(c, a, 1'($urandom), $urandom_range(1, 4), 4'($urandom), $urandom,
                "R2/R4/R6 random");
            gap = $urandom_range(0, 2);
            repeat (gap) @(negedge clk);
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule